// File: doc/BRIEF.md
# Half-Bridge Gate Control Logic

This block is the digital core that sits in front of a high-voltage totem-pole output stage. It turns logic commands into two separate switch enables: one for the high-side switch, which pulls the output to the positive rail, and one for the low-side switch, which pulls it to the negative rail. A 2-bit code on the output reports the resulting output state. The block never turns both switches on at once.

There are two command modes. In dual-input mode each switch follows its own command line. In single-input mode one line chooses the side, and the block inserts a programmable dead time with both switches off whenever the chosen side changes.

Several conditions override the command path:
- An active-low global enable floats the output.
- Each output level is held for a minimum number of cycles before it may change.
- Two comparator flags give pulse-by-pulse overcurrent protection. A flag cuts off its own switch, and that switch stays off until it is commanded off and then on again.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While reset is asserted, hi_on_o, lo_on_o, out_state_o and oc_stat_o are all zero.
- R2: Raising en_n_i turns both switches off exactly 3 clock edges later, even if the current level has not been held for its minimum time.
- R3: With mode_i high (dual-input mode), nin_i=0 with pin_i=0 turns on the high side only, and nin_i=1 with pin_i=1 turns on the low side only. nin_i=0 with pin_i=1 turns both sides off.
- R4: With mode_i high, the forbidden pair nin_i=1 with pin_i=0 turns both switches off.
- R5: With mode_i low (single-input mode), nin_i=1 selects the high side and nin_i=0 selects the low side. pin_i has no effect on the outputs.
- R6: In single-input mode, a change of side leaves both switches off for exactly DEAD_CYC cycles (default 20) before the new side turns on.
- R7: hi_on_o and lo_on_o are never high in the same cycle.
- R8: Once a side turns on, it stays on for at least MIN_CYC cycles (default 50) before the command path may turn it off. Only the enable and an overcurrent trip can end it sooner.
- R9: An overcurrent flag (oc_hi_i for the high side, oc_lo_i for the low side) that is raised while its side is on turns that side off exactly 3 edges later. The matching oc_stat_o bit (bit 0 for the high side, bit 1 for the low side) sets on the same edge.
- R10: A tripped side stays off after its flag drops. Its latch and status bit clear only after the command turns that side off, and the side turns on again on the next on-command.
- R11: out_state_o is 2'b00 when the output floats, 2'b01 when the high side is on and 2'b10 when the low side is on.
- R12: When no hold or dead time is pending, a command change reaches the outputs 3 clock edges after it is applied (two synchronizer flops plus one state register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n_i | input | 1 | Active-low global enable; high floats the output |
| mode_i | input | 1 | 1 = dual-input mode, 0 = single-input mode with dead time |
| nin_i | input | 1 | Low-side command in dual mode; side select in single mode |
| pin_i | input | 1 | Active-low high-side command in dual mode; ignored in single mode |
| oc_hi_i | input | 1 | High-side overcurrent comparator flag |
| oc_lo_i | input | 1 | Low-side overcurrent comparator flag |
| hi_on_o | output | 1 | High-side switch enable |
| lo_on_o | output | 1 | Low-side switch enable |
| out_state_o | output | 2 | Output state code (see R11) |
| oc_stat_o | output | 2 | Overcurrent latch status: bit 0 high side, bit 1 low side |

## Verification
Two pairs of functions can act in the same cycle.

The first pair is the minimum-hold timer and a request to change side. The bench reverses the single-mode side select right after a level turns on. It then checks that the level stays on until cycle MIN_CYC and that the opposite side comes on only after a further DEAD_CYC off cycles.

The second pair is the global enable and a hold that is still running. The bench raises the enable while a freshly started level is held and checks that the enable wins after three edges.

The checker covers the same overlaps in general. It requires that a level ending early was always caused by the enable or by an overcurrent latch that set on that edge.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

  // Output level; the encoding is also the out_state_o code.
  typedef enum logic [1:0] {
    LVL_OFF = 2'b00,
    LVL_HI  = 2'b01,
    LVL_LO  = 2'b10
  } lvl_t;

  // Requested level from the synchronized command inputs.
  function automatic lvl_t decode_req(input logic dual, input logic n, input logic p);
    if (!dual) return n ? LVL_HI : LVL_LO;
    case ({n, p})
      2'b00:   return LVL_HI;
      2'b11:   return LVL_LO;
      default: return LVL_OFF;  // floating, or blocked shoot-through pair
    endcase
  endfunction

  // True when a move goes from one driven side straight to the other.
  function automatic logic is_swap(input lvl_t from, input lvl_t to);
    return (from != LVL_OFF) && (to != LVL_OFF) && (from != to);
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int unsigned W      = 6,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/hb_sequencer.sv
module hb_sequencer
  import hb_gate_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 20,
  parameter int unsigned MIN_CYC  = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_s,
  input  logic mode_s,
  input  logic n_s,
  input  logic p_s,
  output lvl_t lvl,
  output logic hi_cmd,
  output logic lo_cmd
);

  localparam int unsigned DW = $clog2(DEAD_CYC + 1);
  localparam int unsigned HW = $clog2(MIN_CYC + 1);

  lvl_t          cur;
  lvl_t          req;
  logic [DW-1:0] dcnt;
  logic [HW-1:0] hcnt;

  // Off-gap load: DEAD_CYC cycles in single mode, one cycle in dual mode.
  function automatic logic [DW-1:0] gap_load(input logic dual);
    return dual ? '0 : DW'(DEAD_CYC - 1);
  endfunction

  assign req = decode_req(mode_s, n_s, p_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= LVL_OFF;
      dcnt <= '0;
      hcnt <= '0;
    end else if (en_s) begin
      cur  <= LVL_OFF;
      dcnt <= gap_load(mode_s);
      hcnt <= '0;
    end else if (cur == LVL_OFF) begin
      if (dcnt != '0) begin
        dcnt <= dcnt - 1'b1;
      end else if (req != LVL_OFF) begin
        cur  <= req;
        hcnt <= HW'(MIN_CYC - 1);
      end
    end else begin
      if (hcnt != '0) begin
        hcnt <= hcnt - 1'b1;
      end else if (req != cur) begin
        cur  <= LVL_OFF;
        dcnt <= is_swap(cur, req) ? gap_load(mode_s) : '0;
      end
    end
  end

  assign lvl    = cur;
  assign hi_cmd = (cur == LVL_HI);
  assign lo_cmd = (cur == LVL_LO);

endmodule

// File: rtl/hb_oc_latch.sv
module hb_oc_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd,
  input  logic trip,
  output logic gate_o,
  output logic lat_o
);

  logic lat;

  // Set has priority; clears only while the side is commanded off.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lat <= 1'b0;
    else if (trip && cmd) lat <= 1'b1;
    else if (!cmd)        lat <= 1'b0;
  end

  assign gate_o = cmd & ~lat;
  assign lat_o  = lat;

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_gate_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEAD_CYC    = 20,
  parameter int unsigned MIN_CYC     = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_n_i,
  input  logic       mode_i,
  input  logic       nin_i,
  input  logic       pin_i,
  input  logic       oc_hi_i,
  input  logic       oc_lo_i,
  output logic       hi_on_o,
  output logic       lo_on_o,
  output logic [1:0] out_state_o,
  output logic [1:0] oc_stat_o
);

  localparam int unsigned NSIG = 6;

  logic [NSIG-1:0] syn;
  logic en_s, mode_s, n_s, p_s, oc_hi_s, oc_lo_s;
  lvl_t lvl;
  logic hi_cmd, lo_cmd;
  logic [1:0] cmd_v, trip_v, gate_v, lat_v;

  hb_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(6'b000001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({oc_lo_i, oc_hi_i, pin_i, nin_i, mode_i, en_n_i}),
    .q(syn)
  );

  assign {oc_lo_s, oc_hi_s, p_s, n_s, mode_s, en_s} = syn;

  hb_sequencer #(.DEAD_CYC(DEAD_CYC), .MIN_CYC(MIN_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .en_s(en_s), .mode_s(mode_s),
    .n_s(n_s), .p_s(p_s), .lvl(lvl), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd)
  );

  assign cmd_v  = {lo_cmd, hi_cmd};
  assign trip_v = {oc_lo_s, oc_hi_s};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_side
      hb_oc_latch u_oc (
        .clk(clk), .rst_n(rst_n), .cmd(cmd_v[g]), .trip(trip_v[g]),
        .gate_o(gate_v[g]), .lat_o(lat_v[g])
      );
    end
  endgenerate

  assign hi_on_o     = gate_v[0];
  assign lo_on_o     = gate_v[1];
  assign out_state_o = {lo_on_o, hi_on_o};
  assign oc_stat_o   = lat_v;

endmodule

// File: rtl/hb_gate_chk.sv
module hb_gate_chk #(
  parameter int unsigned DEAD_CYC    = 20,
  parameter int unsigned MIN_CYC     = 50,
  parameter int unsigned OC_BOUND_CYC = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en_s,
  input logic       mode_s,
  input logic       oc_hi_s,
  input logic       oc_lo_s,
  input logic       hi_cmd,
  input logic       lo_cmd,
  input logic       oc_hi_i,
  input logic       oc_lo_i,
  input logic       hi_on_o,
  input logic       lo_on_o,
  input logic [1:0] out_state_o,
  input logic [1:0] oc_stat_o
);

  logic [15:0] run_q, off_q, ochi_q, oclo_q;
  logic [1:0]  prev_state, prev_oc, last_side;
  logic        prev_en, single_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0; off_q <= '0; ochi_q <= '0; oclo_q <= '0;
      prev_state <= '0; prev_oc <= '0; last_side <= '0;
      prev_en <= 1'b1; single_ok <= 1'b0;
    end else begin
      run_q      <= (out_state_o == prev_state) ? ((run_q == 16'hFFFF) ? run_q : run_q + 1'b1) : 16'd1;
      prev_state <= out_state_o;
      prev_oc    <= oc_stat_o;
      prev_en    <= en_s;
      off_q      <= (out_state_o == 2'b00) ? ((off_q == 16'hFFFF) ? off_q : off_q + 1'b1) : '0;
      last_side  <= (out_state_o != 2'b00) ? out_state_o : last_side;
      single_ok  <= (out_state_o != 2'b00) ? !mode_s : (single_ok & !mode_s);
      ochi_q     <= (oc_hi_i && hi_on_o) ? ochi_q + 1'b1 : '0;
      oclo_q     <= (oc_lo_i && lo_on_o) ? oclo_q + 1'b1 : '0;
    end
  end

  p_both_off_r7: assert property (@(posedge clk) disable iff (!rst_n) !(hi_on_o && lo_on_o));

  p_enable_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_s |=> (out_state_o == 2'b00));

  p_dead_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_state_o != 2'b00 && last_side != 2'b00 && out_state_o != last_side && single_ok)
      |-> (off_q >= 16'(DEAD_CYC)));

  p_min_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_state != 2'b00 && out_state_o != prev_state && !prev_en && oc_stat_o == prev_oc)
      |-> (run_q >= 16'(MIN_CYC)));

  p_oc_cut_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_hi_s && hi_cmd) |=> !hi_on_o);

  p_oc_cut_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_lo_s && lo_cmd) |=> !lo_on_o);

  p_oc_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ochi_q < 16'(OC_BOUND_CYC)) && (oclo_q < 16'(OC_BOUND_CYC)));

  p_latch_clear_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oc_stat_o[0]) |-> !$past(hi_cmd));

  p_latch_clear_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oc_stat_o[1]) |-> !$past(lo_cmd));

endmodule

bind hb_gate_ctrl hb_gate_chk #(.DEAD_CYC(DEAD_CYC), .MIN_CYC(MIN_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_s(en_s), .mode_s(mode_s),
  .oc_hi_s(oc_hi_s), .oc_lo_s(oc_lo_s), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
  .oc_hi_i(oc_hi_i), .oc_lo_i(oc_lo_i), .hi_on_o(hi_on_o), .lo_on_o(lo_on_o),
  .out_state_o(out_state_o), .oc_stat_o(oc_stat_o)
);

// File: tb/sim_hb_gate_ctrl.sv
module sim_hb_gate_ctrl;

  localparam int DEAD = 20;
  localparam int HOLD = 50;
  localparam int LAT  = 3;
  localparam int NV   = 11;
  // {en_n, mode, nin, pin, exp_hi, exp_lo}
  localparam logic [5:0] VEC [NV] = '{
    6'b1_1_0_0_0_0,  // R2 disabled
    6'b0_1_0_0_1_0,  // R3 positive rail
    6'b0_1_0_1_0_0,  // R3 float
    6'b0_1_1_1_0_1,  // R3 negative rail
    6'b0_1_1_0_0_0,  // R4 blocked pair
    6'b0_0_1_0_1_0,  // R5 single high
    6'b0_0_1_1_1_0,  // R5 pin ignored
    6'b0_0_0_1_0_1,  // R5 single low
    6'b0_0_0_0_0_1,  // R5 pin ignored
    6'b1_0_1_0_0_0,  // R2 disabled
    6'b0_1_0_0_1_0   // R3 positive rail again
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic en_n = 1'b1, mode = 1'b1, nin = 1'b0, pin = 1'b0, ochi = 1'b0, oclo = 1'b0;
  logic hi_on, lo_on;
  logic [1:0] st, oc_st;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hb_gate_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .en_n_i(en_n), .mode_i(mode), .nin_i(nin), .pin_i(pin),
    .oc_hi_i(ochi), .oc_lo_i(oclo), .hi_on_o(hi_on), .lo_on_o(lo_on),
    .out_state_o(st), .oc_stat_o(oc_st)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {hi, lo, state code}
  function automatic logic [3:0] expo(input logic h, input logic l);
    return {h, l, l, h};  // R11: code = {lo, hi}
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    step(3);
    chk("R1 reset outputs", {hi_on, lo_on, st}, 4'b0000);
    chk("R1 reset status", {2'b00, oc_st}, 4'b0000);
    rst_n = 1'b1;
    step(2);

    for (int i = 0; i < NV; i++) begin
      {en_n, mode, nin, pin} = VEC[i][5:2];
      step(100);
      chk($sformatf("R3/R4/R5/R11 vector %0d", i), {hi_on, lo_on, st},
          expo(VEC[i][1], VEC[i][0]));
    end

    // R9: high-side trip, exact latency
    ochi = 1'b1;
    step(LAT - 1);
    chk("R9 hi before cut", {3'b000, hi_on}, 4'b0001);
    step(1);
    chk("R9 hi cut", {hi_on, lo_on, oc_st}, 4'b0001);
    ochi = 1'b0;
    step(10);
    chk("R10 hi stays latched", {hi_on, lo_on, oc_st}, 4'b0001);
    pin = 1'b1;
    step(10);
    chk("R10 latch cleared by off", {hi_on, lo_on, oc_st}, 4'b0000);
    pin = 1'b0;
    step(10);
    chk("R10 hi back on", {hi_on, lo_on, oc_st}, 4'b1000);

    // R9: low-side trip
    nin = 1'b1; pin = 1'b1;
    step(100);
    chk("R3 low on before trip", {hi_on, lo_on, st}, expo(1'b0, 1'b1));
    oclo = 1'b1;
    step(LAT);
    chk("R9 lo cut", {hi_on, lo_on, oc_st}, 4'b0010);
    oclo = 1'b0;
    step(20);
    chk("R10 lo stays latched", {hi_on, lo_on, oc_st}, 4'b0010);

    // R6/R12: single mode to high side, then swap with dead time
    mode = 1'b0; nin = 1'b1;
    step(100);
    chk("R5 single high", {hi_on, lo_on, oc_st}, 4'b1000);
    nin = 1'b0;
    step(LAT - 1);
    chk("R12 hi before latency", {hi_on, lo_on, 2'b00}, 4'b1000);
    step(1);
    chk("R12 hi off at latency", {hi_on, lo_on, 2'b00}, 4'b0000);
    step(DEAD - 1);
    chk("R6 still dead", {hi_on, lo_on, 2'b00}, 4'b0000);
    step(1);
    chk("R6 lo on after dead", {hi_on, lo_on, 2'b00}, 4'b0100);

    // R8: reverse immediately; low side must hold HOLD cycles
    nin = 1'b1;
    step(HOLD - 1);
    chk("R8 lo held", {hi_on, lo_on, 2'b00}, 4'b0100);
    step(1);
    chk("R8 lo released", {hi_on, lo_on, 2'b00}, 4'b0000);
    step(DEAD - 1);
    chk("R6 hi not yet", {hi_on, lo_on, 2'b00}, 4'b0000);
    step(1);
    chk("R6 hi on after dead", {hi_on, lo_on, 2'b00}, 4'b1000);

    // R2: enable overrides a fresh hold
    en_n = 1'b1;
    step(LAT - 1);
    chk("R2 hi before enable latency", {hi_on, lo_on, 2'b00}, 4'b1000);
    step(1);
    chk("R2 disabled mid-hold", {hi_on, lo_on, st}, 4'b0000);

    // R1: reset mid-run
    en_n = 1'b0; mode = 1'b1; nin = 1'b0; pin = 1'b0;
    step(100);
    chk("R3 on before reset", {hi_on, lo_on, st}, expo(1'b1, 1'b0));
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", {hi_on, lo_on, st}, 4'b0000);
    step(2);
    rst_n = 1'b1;
    step(2);

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

endmodule